// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a transmit command FIFO and a byte-level I2C bit engine. It turns a stream of 11-bit command words into bus operations. Each operation is a START, a STOP, a byte write or a byte read. The block generates the address phase for 7-bit or 10-bit targets. When the direction changes, or when a command asks for it, the block inserts a repeated START. Bytes read from the bus are pushed to a receive FIFO.

Between bytes the master keeps the bus if no command is waiting and the last byte carried no STOP flag. A NACK from the target aborts the transfer. The block then pulses a flush for both FIFOs, records why it aborted and closes the bus with a STOP. Status outputs report activity, hold, START and STOP completion, and abort events.

The bit engine connects through a level request and a one-cycle done pulse. The FIFOs connect through a valid/pop pair and an unconditional push.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word holds write data in bits 7:0. Bit 8 requests a one-byte read, bit 9 requests a STOP after the byte, and bit 10 requests a repeated START before the byte. Engine operations are coded 0 = START, 1 = STOP, 2 = write byte, 3 = read byte. `eng_req_o`, the operation code and the write byte stay steady until `eng_done_i` is seen.
- R2: A transfer begins only when `enable_i` is high and a command is waiting. While disabled, no command is popped and no engine request is made.
- R3: With `tar_i[12]` low, the first byte after START is `{tar_i[6:0], dir}`, where dir is 1 for read.
- R4: With `tar_i[12]` high, the address phase is `{5'b11110, tar[9:8], 0}` followed by `tar[7:0]`. For a read, a repeated START and then `{5'b11110, tar[9:8], 1}` follow.
- R5: A write command sends its data byte. A read command issues a read with write byte 0 and ignores its data field. The received byte appears on `rx_data_o` with `rx_valid_o` in the cycle that the engine completes the read.
- R6: For reads, `eng_ack_o` is 0 (ACK), except on a read whose command has the STOP flag, where it is 1 (NACK).
- R7: After a byte with the STOP flag, a STOP is issued. `stop_det_o` pulses when it completes and `activity_o` falls on the next cycle. `activity_o` is high from the first START until then.
- R8: A restart flag on a later command produces a START and a full address phase before its byte. `start_det_o` pulses once for every completed START, including repeated ones.
- R9: A command whose direction differs from the current one produces a repeated START and address even without the restart flag.
- R10: When the queue is empty and the last byte had no STOP flag, `hold_o` is high, no request is made and `activity_o` stays high. The transfer resumes when a command arrives.
- R11: A NACK on an address byte or a written byte pulses `abort_o` and `flush_o`, then a STOP is issued and the block returns to idle. `abort_src_o` becomes 01 for an address NACK or 10 for a data NACK. It keeps that value until the next transfer starts, which clears it.
- R12: The target address is captured when a transfer starts. Changes to `tar_i` during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new transfers to start |
| tar_i | input | 13 | Target address; bit 12 selects 10-bit mode |
| cmd_valid_i | input | 1 | Command FIFO not empty |
| cmd_i | input | 11 | Command word at the FIFO head |
| cmd_ready_o | output | 1 | Pops the FIFO head |
| rx_valid_o | output | 1 | Pushes a received byte |
| rx_data_o | output | 8 | Received byte |
| flush_o | output | 1 | Discards both FIFOs' contents |
| eng_req_o | output | 1 | Operation request to the bit engine |
| eng_op_o | output | 2 | Operation code |
| eng_wdata_o | output | 8 | Byte to send |
| eng_ack_o | output | 1 | For reads, 1 sends NACK |
| eng_done_i | input | 1 | Operation complete pulse |
| eng_nack_i | input | 1 | Target NACKed the written byte (with done) |
| eng_rdata_i | input | 8 | Byte read (with done) |
| activity_o | output | 1 | Master busy |
| hold_o | output | 1 | Bus held waiting for commands |
| start_det_o | output | 1 | START completed |
| stop_det_o | output | 1 | STOP completed |
| abort_o | output | 1 | Transfer aborted |
| abort_src_o | output | 2 | Abort reason: bit 0 address, bit 1 data |

## Verification
The sequencer is tried with single-direction writes, multi-byte reads, a write followed by a read with no restart flag, and a restart flag on commands in the same direction. Together these separate an explicit restart from one implied by a direction change, and show that only the STOP-flagged read is NACKed. 7-bit and 10-bit targets, in both directions, show whether the header and low byte are ordered correctly and whether the read header appears after the repeated START. A stall with an empty queue, with the address changed during the stall, shows that the bus is held and that the address was latched. NACK injection on the address byte and on a data byte tells the two abort reasons apart and confirms the flush and the reason's persistence.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 11;
  localparam int TAR_W   = 13;
  localparam int TEN_BIT = 12;
  localparam int SRC_W   = 2;
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WR    = 2'd2,
    OP_RD    = 2'd3
  } op_e;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              read;
    logic [BYTE_W-1:0] data;
  } cmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR_HI, S_ADDR_LO, S_RSTART,
    S_ADDR_HR, S_DATA, S_HOLD, S_STOP
  } state_e;

  typedef enum logic [1:0] {PH_HI, PH_LO, PH_HR} aph_e;
endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
(
  input  logic [TAR_W-1:0]  tar_i,
  input  logic              dir_i,
  input  aph_e              phase_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    unique case (phase_i)
      PH_HI:   byte_o = tar_i[TEN_BIT] ? {HDR10, tar_i[9:8], 1'b0} : {tar_i[6:0], dir_i};
      PH_LO:   byte_o = tar_i[7:0];
      default: byte_o = {HDR10, tar_i[9:8], 1'b1};
    endcase
  end
endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status
  import i2c_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_start_i,
  input  logic             abort_i,
  input  logic             abort_data_i,
  output logic [SRC_W-1:0] abort_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           abort_src_o <= '0;
    else if (xfer_start_i) abort_src_o <= '0;
    else if (abort_i)      abort_src_o <= abort_data_i ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [TAR_W-1:0]  tar_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [BYTE_W-1:0] addr_byte_i,
  output logic              cmd_ready_o,
  output logic              rx_valid_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [BYTE_W-1:0] eng_wdata_o,
  output logic              eng_ack_o,
  output logic              activity_o,
  output logic              hold_o,
  output logic              start_det_o,
  output logic              stop_det_o,
  output logic              abort_o,
  output logic              abort_data_o,
  output logic              xfer_start_o,
  output logic [TAR_W-1:0]  tar_q_o,
  output logic              dir_o,
  output aph_e              phase_o
);
  state_e           state_q;
  cmd_t             cur_q, new_cmd;
  logic             dir_q;
  logic [TAR_W-1:0] tar_q;
  logic             done, addr_st, take_cmd;

  assign new_cmd   = cmd_t'(cmd_i);
  assign eng_req_o = !(state_q inside {S_IDLE, S_HOLD});
  assign done      = eng_req_o && eng_done_i;
  assign addr_st   = state_q inside {S_ADDR_HI, S_ADDR_LO, S_ADDR_HR};

  assign xfer_start_o = (state_q == S_IDLE) && enable_i && cmd_valid_i;
  assign take_cmd     = xfer_start_o || ((state_q == S_HOLD) && cmd_valid_i);
  assign cmd_ready_o  = take_cmd;

  assign abort_o      = done && eng_nack_i && (addr_st || ((state_q == S_DATA) && !cur_q.read));
  assign abort_data_o = (state_q == S_DATA);
  assign start_det_o  = done && (state_q inside {S_START, S_RSTART});
  assign stop_det_o   = done && (state_q == S_STOP);
  assign rx_valid_o   = done && (state_q == S_DATA) && cur_q.read;
  assign activity_o   = (state_q != S_IDLE);
  assign hold_o       = (state_q == S_HOLD);
  assign tar_q_o      = tar_q;
  assign dir_o        = dir_q;

  always_comb begin
    eng_op_o    = OP_WR;
    eng_wdata_o = '0;
    eng_ack_o   = 1'b0;
    phase_o     = PH_HI;
    unique case (state_q)
      S_START, S_RSTART: eng_op_o = OP_START;
      S_STOP:            eng_op_o = OP_STOP;
      S_ADDR_HI:         eng_wdata_o = addr_byte_i;
      S_ADDR_LO: begin phase_o = PH_LO; eng_wdata_o = addr_byte_i; end
      S_ADDR_HR: begin phase_o = PH_HR; eng_wdata_o = addr_byte_i; end
      S_DATA: begin
        eng_op_o    = cur_q.read ? OP_RD : OP_WR;
        eng_wdata_o = cur_q.read ? '0 : cur_q.data;
        eng_ack_o   = cur_q.read && cur_q.stop;  // NACK closes a read
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      dir_q   <= 1'b0;
      tar_q   <= '0;
    end else begin
      if (take_cmd)     cur_q <= new_cmd;
      if (xfer_start_o) tar_q <= tar_i;
      unique case (state_q)
        S_IDLE: if (xfer_start_o) begin
          dir_q   <= new_cmd.read;
          state_q <= S_START;
        end
        S_START:   if (done) state_q <= S_ADDR_HI;
        S_ADDR_HI: if (done) state_q <= abort_o ? S_STOP : (tar_q[TEN_BIT] ? S_ADDR_LO : S_DATA);
        S_ADDR_LO: if (done) state_q <= abort_o ? S_STOP : (dir_q ? S_RSTART : S_DATA);
        S_RSTART:  if (done) state_q <= S_ADDR_HR;
        S_ADDR_HR: if (done) state_q <= abort_o ? S_STOP : S_DATA;
        S_DATA:    if (done) state_q <= (abort_o || cur_q.stop) ? S_STOP : S_HOLD;
        S_HOLD: if (cmd_valid_i) begin
          if (new_cmd.restart || (new_cmd.read != dir_q)) begin
            dir_q   <= new_cmd.read;
            state_q <= S_START;
          end else begin
            state_q <= S_DATA;
          end
        end
        S_STOP:    if (done) state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [TAR_W-1:0]  tar_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              cmd_ready_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              flush_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [BYTE_W-1:0] eng_wdata_o,
  output logic              eng_ack_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [BYTE_W-1:0] eng_rdata_i,
  output logic              activity_o,
  output logic              hold_o,
  output logic              start_det_o,
  output logic              stop_det_o,
  output logic              abort_o,
  output logic [SRC_W-1:0]  abort_src_o
);
  logic [BYTE_W-1:0] addr_byte;
  logic [TAR_W-1:0]  tar_q;
  logic              dir, abort_data, xfer_start;
  aph_e              phase;

  i2c_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .enable_i, .tar_i, .cmd_valid_i, .cmd_i,
    .eng_done_i, .eng_nack_i,
    .addr_byte_i  (addr_byte),
    .cmd_ready_o, .rx_valid_o, .eng_req_o, .eng_op_o, .eng_wdata_o, .eng_ack_o,
    .activity_o, .hold_o, .start_det_o, .stop_det_o, .abort_o,
    .abort_data_o (abort_data),
    .xfer_start_o (xfer_start),
    .tar_q_o      (tar_q),
    .dir_o        (dir),
    .phase_o      (phase)
  );

  i2c_seq_addr u_addr (
    .tar_i   (tar_q),
    .dir_i   (dir),
    .phase_i (phase),
    .byte_o  (addr_byte)
  );

  i2c_seq_status u_status (
    .clk_i, .rst_ni,
    .xfer_start_i (xfer_start),
    .abort_i      (abort_o),
    .abort_data_i (abort_data),
    .abort_src_o
  );

  assign rx_data_o = eng_rdata_i;
  assign flush_o   = abort_o;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       rx_valid_o,
  input logic       eng_req_o,
  input logic [1:0] eng_op_o,
  input logic [7:0] eng_wdata_o,
  input logic       eng_done_i,
  input logic       activity_o,
  input logic       hold_o,
  input logic       stop_det_o,
  input logic       abort_o
);
  assert_req_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_wdata_o));

  assert_pop_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> cmd_valid_i);

  assert_start_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(activity_o) |-> $past(enable_i));

  assert_rx_in_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> activity_o);

  assert_idle_after_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> !activity_o);

  assert_hold_waits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !cmd_valid_i |=> hold_o && activity_o);

  assert_abort_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> eng_req_o && (eng_op_o == 2'd1));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/i2c_cmd_seq_tb.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb;
  logic        clk = 0, rst_ni = 0, enable_i = 0;
  logic [12:0] tar_i = 13'h052;
  logic        cmd_valid_i;
  logic [10:0] cmd_i;
  logic        cmd_ready_o, rx_valid_o, flush_o, eng_req_o, eng_ack_o;
  logic [7:0]  rx_data_o, eng_wdata_o;
  logic [1:0]  eng_op_o, abort_src_o;
  logic        eng_done_i = 0, eng_nack_i = 0;
  logic [7:0]  eng_rdata_i = 0;
  logic        activity_o, hold_o, start_det_o, stop_det_o, abort_o;

  always #2.5 clk = ~clk;

  i2c_cmd_seq u_dut (.clk_i(clk), .*);

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // command FIFO model
  logic [10:0] fifo [64];
  int wr_p = 0, rd_p = 0;
  assign cmd_valid_i = (wr_p != rd_p);
  assign cmd_i = fifo[rd_p % 64];
  always @(posedge clk) begin
    if (flush_o) rd_p <= wr_p;
    else if (cmd_ready_o) rd_p <= rd_p + 1;
  end
  task automatic push_cmd(input bit rs, input bit st, input bit rd, input logic [7:0] d);
    @(negedge clk);
    fifo[wr_p % 64] = {rs, st, rd, d};
    wr_p++;
  endtask

  // bit engine model: done two cycles after request seen
  int eng_cnt = 0, op_cnt = 0, rd_idx = 0, nack_at = -1;
  always @(posedge clk) begin
    if (eng_done_i) begin
      eng_done_i <= 0;
      eng_nack_i <= 0;
    end else if (eng_req_o) begin
      if (eng_cnt == 1) begin
        eng_cnt    <= 0;
        eng_done_i <= 1;
        eng_nack_i <= (op_cnt == nack_at);
        op_cnt     <= op_cnt + 1;
        if (eng_op_o == 2'd3) begin
          eng_rdata_i <= 8'h5A ^ 8'(rd_idx);
          rd_idx      <= rd_idx + 1;
        end
      end else eng_cnt <= eng_cnt + 1;
    end
  end

  // scoreboard
  logic [10:0] exp_q[$];
  logic [7:0]  rx_q[$];
  int exp_cnt = 0, exp_rd = 0;
  int starts = 0, stops = 0, aborts = 0, flushes = 0;

  task automatic exp_op(input logic [1:0] op, input logic [7:0] d, input bit ack);
    exp_q.push_back({op, d, ack});
    exp_cnt++;
    if (op == 2'd3) begin
      rx_q.push_back(8'h5A ^ 8'(exp_rd));
      exp_rd++;
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    if (eng_req_o && eng_done_i) begin
      if (exp_q.size() == 0) chk(0, cur_req, {eng_op_o, eng_wdata_o, eng_ack_o}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({eng_op_o, eng_wdata_o, eng_ack_o} == e, cur_req, {eng_op_o, eng_wdata_o, eng_ack_o}, e);
      end
    end
    if (rx_valid_o) begin
      if (rx_q.size() == 0) chk(0, "R5", rx_data_o, 0);
      else begin
        logic [7:0] r;
        r = rx_q.pop_front();
        chk(rx_data_o == r, "R5", rx_data_o, r);
      end
    end
    if (start_det_o) starts++;
    if (stop_det_o)  stops++;
    if (abort_o)     aborts++;
    if (flush_o)     flushes++;
  end

  localparam logic [1:0] ST = 2'd0, SP = 2'd1, WR = 2'd2, RD = 2'd3;
  function automatic logic [7:0] a7(input logic [12:0] t, input bit rd);
    return {t[6:0], rd};
  endfunction
  function automatic logic [7:0] h10(input logic [12:0] t, input bit rd);
    return {5'b11110, t[9:8], rd};
  endfunction

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (activity_o || cmd_valid_i) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, exp_q.size(), 0);
    chk(rx_q.size() == 0, "R5", rx_q.size(), 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, p0;
    repeat (3) @(negedge clk);
    chk(activity_o == 0 && eng_req_o == 0 && hold_o == 0 && abort_src_o == 0, "R7 reset",
        {activity_o, eng_req_o, hold_o, abort_src_o}, 0);
    rst_ni = 1;

    // R2: disabled, nothing happens
    cur_req = "R2 R3 R5";
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'h11, 0); exp_op(SP, 0, 0);
    push_cmd(0, 1, 0, 8'h11);
    repeat (20) @(negedge clk);
    chk(activity_o == 0 && eng_req_o == 0 && cmd_valid_i, "R2", {activity_o, eng_req_o}, 0);
    s0 = starts; p0 = stops;
    enable_i = 1;
    wait_idle();
    chk(starts == s0 + 1, "R8", starts - s0, 1);
    chk(stops == p0 + 1, "R7", stops - p0, 1);

    // R6: two reads, only the stop read NACKs; data field ignored
    cur_req = "R5 R6";
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 1), 0); exp_op(RD, 0, 0); exp_op(RD, 0, 1); exp_op(SP, 0, 0);
    push_cmd(0, 0, 1, 8'hEE); push_cmd(0, 1, 1, 8'hCD);
    wait_idle();

    // R9: direction change without restart flag
    cur_req = "R9";
    s0 = starts;
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'h33, 0);
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 1), 0); exp_op(RD, 0, 1); exp_op(SP, 0, 0);
    push_cmd(0, 0, 0, 8'h33); push_cmd(0, 1, 1, 8'h00);
    wait_idle();
    chk(starts == s0 + 2, "R9", starts - s0, 2);

    // R8: explicit restart, same direction
    cur_req = "R8";
    s0 = starts;
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'h44, 0);
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'h55, 0); exp_op(SP, 0, 0);
    push_cmd(0, 0, 0, 8'h44); push_cmd(1, 1, 0, 8'h55);
    wait_idle();
    chk(starts == s0 + 2, "R8", starts - s0, 2);

    // R4: 10-bit write then read
    enable_i = 0;
    tar_i = 13'h1000 | 13'h2B7;
    @(negedge clk);
    enable_i = 1;
    cur_req = "R4 write";
    exp_op(ST, 0, 0); exp_op(WR, h10(tar_i, 0), 0); exp_op(WR, tar_i[7:0], 0);
    exp_op(WR, 8'h66, 0); exp_op(SP, 0, 0);
    push_cmd(0, 1, 0, 8'h66);
    wait_idle();
    cur_req = "R4 read";
    exp_op(ST, 0, 0); exp_op(WR, h10(tar_i, 0), 0); exp_op(WR, tar_i[7:0], 0);
    exp_op(ST, 0, 0); exp_op(WR, h10(tar_i, 1), 0); exp_op(RD, 0, 1); exp_op(SP, 0, 0);
    push_cmd(0, 1, 1, 8'h00);
    wait_idle();

    // R10 + R12: hold with empty queue, address change ignored
    enable_i = 0;
    tar_i = 13'h052;
    @(negedge clk);
    enable_i = 1;
    cur_req = "R10 R12";
    exp_op(ST, 0, 0); exp_op(WR, a7(13'h052, 0), 0); exp_op(WR, 8'h77, 0);
    push_cmd(0, 0, 0, 8'h77);
    repeat (30) @(negedge clk);
    chk(hold_o == 1 && activity_o == 1 && eng_req_o == 0, "R10", {hold_o, activity_o, eng_req_o}, 3'b110);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    tar_i = 13'h019;
    exp_op(ST, 0, 0); exp_op(WR, a7(13'h052, 0), 0); exp_op(WR, 8'h78, 0); exp_op(SP, 0, 0);
    push_cmd(1, 1, 0, 8'h78);
    wait_idle();
    chk(hold_o == 0, "R10", hold_o, 0);
    tar_i = 13'h052;

    // R11: address NACK
    cur_req = "R11 addr";
    s0 = aborts; p0 = flushes;
    nack_at = exp_cnt + 1;
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(SP, 0, 0);
    push_cmd(0, 0, 0, 8'h80); push_cmd(0, 1, 0, 8'h81);
    wait_idle();
    chk(aborts == s0 + 1 && flushes == p0 + 1, "R11", aborts - s0, 1);
    chk(abort_src_o == 2'b01, "R11", abort_src_o, 1);
    chk(wr_p == rd_p, "R11 flush", wr_p - rd_p, 0);

    // R11: data NACK
    cur_req = "R11 data";
    nack_at = exp_cnt + 2;
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'h90, 0); exp_op(SP, 0, 0);
    push_cmd(0, 0, 0, 8'h90); push_cmd(0, 0, 0, 8'h91); push_cmd(0, 1, 0, 8'h92);
    wait_idle();
    chk(abort_src_o == 2'b10, "R11", abort_src_o, 2);
    chk(wr_p == rd_p, "R11 flush", wr_p - rd_p, 0);

    // R11: reason clears on next transfer start
    cur_req = "R11 clear";
    nack_at = -1;
    exp_op(ST, 0, 0); exp_op(WR, a7(tar_i, 0), 0); exp_op(WR, 8'hA1, 0); exp_op(SP, 0, 0);
    push_cmd(0, 1, 0, 8'hA1);
    wait_idle();
    chk(abort_src_o == 2'b00, "R11", abort_src_o, 0);
    chk(activity_o == 0, "R7", activity_o, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule